// File: doc/BRIEF.md
# Instruction-Boundary Interrupt and DMA Arbiter

This block sits next to the sequencer of a 16-bit processor. It decides what happens at each instruction boundary: execution continues, an interrupt is taken, or the bus is handed to an external DMA master. Three request lines arrive asynchronously and active low:
- a maskable interrupt request;
- a non-maskable interrupt request;
- a DMA bus request.

Each line goes through its own two-flop synchroniser and a falling-edge detector. The sequencer reports each finished instruction with a strobe and says whether that instruction may be interrupted. It also pulses the block when the program enables or disables interrupts.

Two gates decide whether a request is acted on:
- Requests are looked at only at boundaries marked interruptible.
- The interrupt-enable flag applies only to the maskable line.

A DMA request wins over interrupts. The block drives an active-low acknowledge while the processor is parked, and it signals resumption once the requester lets go. An interrupt is redirected to a fixed vector. A maskable request whose line rises again before it is serviced is forgotten.

The controller has two states, `ST_RUN` and `ST_HOLD`, and three transitions:
- **grant** (`ST_RUN` to `ST_HOLD`): at an interruptible boundary while a DMA request is pending.
- **release** (`ST_HOLD` to `ST_RUN`): once the synchronised DMA line is high again.
- **dispatch** (`ST_RUN` to `ST_RUN`): at an interruptible boundary with no DMA request but an interrupt that may be taken.

All outputs are registered.

Top module: `irq_bus_arbiter`

## Requirements
- R1: After reset, `take_irq` is 0, `irq_vector` is 0, `dma_ack_n` is 1 and `resume` is 0. The interrupt-enable flag is clear.
- R2: The enable flag is set by `ie_set` and cleared by `ie_clr` in the following cycle, with clear winning if both are present. A falling edge on `irq_mask_n` makes a maskable interrupt pending only while the flag is set. A pending maskable interrupt is taken only if the flag is still set at the boundary.
- R3: If `irq_mask_n` returns high before the maskable interrupt is taken, the pending request is dropped.
- R4: A falling edge on `irq_force_n` makes an interrupt pending whatever the state of the enable flag.
- R5: Pending requests are acted on only in a cycle with `insn_done`=1 and `insn_intr`=1. A boundary with `insn_intr`=0 and cycles without `insn_done` change no output.
- R6: Taking an interrupt raises `take_irq` for exactly one cycle, in the cycle after the boundary, with `irq_vector`=0x1004 during that cycle. Otherwise `irq_vector` is 0. If both interrupt kinds are pending at one boundary, only the non-maskable one is taken and the maskable one stays pending for a later boundary.
- R7: A falling edge on `dma_req_n` is granted at the next interruptible boundary, regardless of the enable flag. `dma_ack_n` goes low in the cycle after that boundary and stays low while the request is held.
- R8: A DMA request whose line returns high before any interruptible boundary is dropped, and no acknowledge is produced.
- R9: Once the synchronised `dma_req_n` is high during a grant, `dma_ack_n` returns to 1 and `resume` pulses for one cycle, both in the same cycle.
- R10: A DMA request pending at the same boundary as an interrupt is granted first. The interrupt stays pending and is taken in the same cycle as `resume`.
- R11: Boundary strobes that arrive while the bus is granted are ignored. Neither `take_irq` nor the acknowledge changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_mask_n | input | 1 | Maskable interrupt request, active low, asynchronous |
| irq_force_n | input | 1 | Non-maskable interrupt request, active low, asynchronous |
| dma_req_n | input | 1 | DMA bus request, active low, asynchronous |
| insn_done | input | 1 | One-cycle strobe: an instruction has finished |
| insn_intr | input | 1 | With `insn_done`: the finished instruction is interruptible |
| ie_set | input | 1 | Pulse: set the interrupt-enable flag |
| ie_clr | input | 1 | Pulse: clear the interrupt-enable flag |
| take_irq | output | 1 | One-cycle pulse: redirect execution to the interrupt vector |
| irq_vector | output | VEC_W | Interrupt vector while `take_irq` is high, otherwise 0 |
| dma_ack_n | output | 1 | Bus acknowledge, active low |
| resume | output | 1 | One-cycle pulse: execution continues after a grant |

## Verification
The hardest case to reach is the release of a grant with an interrupt still waiting, because the DMA edge and the interrupt edge must both be latched before a single interruptible boundary. The stimulus lowers both lines and waits out the synchroniser latency before it issues the boundary strobe. It then issues more boundary strobes during the grant to show they are ignored, and finally raises the DMA line. The scoreboard expects the resume and the interrupt in the same monitor cycle, with the resume first. Dropped requests are shown by the absence of any event after a later interruptible boundary.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } arb_state_t;

    localparam int NUM_LINES = 3;
    localparam int LN_FORCE  = 0;
    localparam int LN_MASK   = 1;
    localparam int LN_DMA    = 2;

endpackage

// File: rtl/arb_edge_sync.sv
module arb_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_n,
    output logic line_high,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain  <= '1;
            last_q <= 1'b1;
        end else begin
            chain  <= {chain[STAGES-2:0], line_n};
            last_q <= chain[STAGES-1];
        end
    end

    assign line_high = chain[STAGES-1];
    assign fall      = last_q & ~chain[STAGES-1];
endmodule

// File: rtl/arb_ie_flag.sv
module arb_ie_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic ie_set,
    input  logic ie_clr,
    output logic ie
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ie <= 1'b0;
        else if (ie_clr) ie <= 1'b0;
        else if (ie_set) ie <= 1'b1;
    end
endmodule

// File: rtl/arb_pending.sv
module arb_pending
    import arb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] fall,
    input  logic [NUM_LINES-1:0] high,
    input  logic                 ie,
    input  logic                 take_force,
    input  logic                 take_mask,
    output logic [NUM_LINES-1:0] pend
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            // non-maskable: held until taken
            if (take_force)          pend[LN_FORCE] <= 1'b0;
            else if (fall[LN_FORCE]) pend[LN_FORCE] <= 1'b1;
            // maskable: latched only while enabled, dropped when line rises
            if (take_mask || high[LN_MASK])  pend[LN_MASK] <= 1'b0;
            else if (fall[LN_MASK] && ie)    pend[LN_MASK] <= 1'b1;
            // DMA: dropped when requester withdraws
            if (high[LN_DMA])        pend[LN_DMA] <= 1'b0;
            else if (fall[LN_DMA])   pend[LN_DMA] <= 1'b1;
        end
    end
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import arb_pkg::*;
#(
    parameter int              VEC_W      = 16,
    parameter logic [VEC_W-1:0] IRQ_VECTOR = 16'h1004
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 boundary,
    input  logic [NUM_LINES-1:0] pend,
    input  logic                 ie,
    input  logic                 dma_high,
    output logic                 take_force,
    output logic                 take_mask,
    output logic                 take_irq,
    output logic [VEC_W-1:0]     irq_vector,
    output logic                 dma_ack_n,
    output logic                 resume
);
    arb_state_t state_q, state_nx;
    logic       take_nx, ack_n_nx, resume_nx;

    // interrupt choice shared by dispatch and release
    logic can_force, can_mask;
    assign can_force = pend[LN_FORCE];
    assign can_mask  = pend[LN_MASK] && ie;

    always_comb begin
        state_nx   = state_q;
        take_nx    = 1'b0;
        ack_n_nx   = 1'b1;
        resume_nx  = 1'b0;
        take_force = 1'b0;
        take_mask  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (boundary) begin
                    if (pend[LN_DMA]) begin
                        state_nx = ST_HOLD;        // grant
                        ack_n_nx = 1'b0;
                    end else if (can_force) begin  // dispatch
                        take_nx    = 1'b1;
                        take_force = 1'b1;
                    end else if (can_mask) begin
                        take_nx   = 1'b1;
                        take_mask = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                ack_n_nx = 1'b0;
                if (dma_high) begin
                    state_nx  = ST_RUN;            // release
                    ack_n_nx  = 1'b1;
                    resume_nx = 1'b1;
                    if (can_force) begin
                        take_nx    = 1'b1;
                        take_force = 1'b1;
                    end else if (can_mask) begin
                        take_nx   = 1'b1;
                        take_mask = 1'b1;
                    end
                end
            end
            default: state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take_irq   <= 1'b0;
            irq_vector <= '0;
            dma_ack_n  <= 1'b1;
            resume     <= 1'b0;
        end else begin
            take_irq   <= take_nx;
            irq_vector <= take_nx ? IRQ_VECTOR : '0;
            dma_ack_n  <= ack_n_nx;
            resume     <= resume_nx;
        end
    end

    assert_hold_no_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_ack_n |-> !take_irq);

    assert_resume_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> (dma_ack_n && $past(!dma_ack_n)));
endmodule

// File: rtl/irq_bus_arbiter.sv
module irq_bus_arbiter
    import arb_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter int               VEC_W       = 16,
    parameter logic [VEC_W-1:0] IRQ_VECTOR  = 16'h1004
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_mask_n,
    input  logic             irq_force_n,
    input  logic             dma_req_n,
    input  logic             insn_done,
    input  logic             insn_intr,
    input  logic             ie_set,
    input  logic             ie_clr,
    output logic             take_irq,
    output logic [VEC_W-1:0] irq_vector,
    output logic             dma_ack_n,
    output logic             resume
);
    logic [NUM_LINES-1:0] raw_n, fall, high, pend;
    logic                 ie, take_force, take_mask, boundary;

    assign raw_n[LN_FORCE] = irq_force_n;
    assign raw_n[LN_MASK]  = irq_mask_n;
    assign raw_n[LN_DMA]   = dma_req_n;
    assign boundary        = insn_done & insn_intr;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_sync
        arb_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_n   (raw_n[g]),
            .line_high(high[g]),
            .fall     (fall[g])
        );
    end

    arb_ie_flag u_ie (
        .clk   (clk),
        .rst_n (rst_n),
        .ie_set(ie_set),
        .ie_clr(ie_clr),
        .ie    (ie)
    );

    arb_pending u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall      (fall),
        .high      (high),
        .ie        (ie),
        .take_force(take_force),
        .take_mask (take_mask),
        .pend      (pend)
    );

    arb_fsm #(.VEC_W(VEC_W), .IRQ_VECTOR(IRQ_VECTOR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .boundary  (boundary),
        .pend      (pend),
        .ie        (ie),
        .dma_high  (high[LN_DMA]),
        .take_force(take_force),
        .take_mask (take_mask),
        .take_irq  (take_irq),
        .irq_vector(irq_vector),
        .dma_ack_n (dma_ack_n),
        .resume    (resume)
    );

    assert_ack_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_ack_n) |-> $past(insn_done && insn_intr));

    assert_take_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && !resume) |-> $past(insn_done && insn_intr));

    assert_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (irq_vector == IRQ_VECTOR));
endmodule

// File: tb/irq_bus_arbiter_tb_top.sv
module irq_bus_arbiter_tb_top;
    localparam int EV_IRQ = 1;
    localparam int EV_ACK = 2;
    localparam int EV_RES = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_mask_n = 1'b1, irq_force_n = 1'b1, dma_req_n = 1'b1;
    logic        insn_done = 1'b0, insn_intr = 1'b0, ie_set = 1'b0, ie_clr = 1'b0;
    logic        take_irq, dma_ack_n, resume;
    logic [15:0] irq_vector;

    int    checks = 0, errors = 0;
    bit    done = 1'b0;
    int    kind_q[$];
    string req_q[$];
    string cur_req = "R1";
    logic  prev_ack = 1'b1;

    always #5 clk = ~clk;

    irq_bus_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .irq_mask_n(irq_mask_n), .irq_force_n(irq_force_n),
        .dma_req_n(dma_req_n), .insn_done(insn_done), .insn_intr(insn_intr),
        .ie_set(ie_set), .ie_clr(ie_clr), .take_irq(take_irq),
        .irq_vector(irq_vector), .dma_ack_n(dma_ack_n), .resume(resume)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input string req);
        kind_q.push_back(kind);
        req_q.push_back(req);
    endtask

    task automatic consume(input int kind);
        if (kind_q.size() == 0) begin
            chk(1'b0, cur_req, "unexpected event", kind, 0);
        end else begin
            int    k = kind_q.pop_front();
            string r = req_q.pop_front();
            chk(k == kind, r, "event kind", kind, k);
        end
    endtask

    // monitor: scoreboard side
    always @(negedge clk) begin
        if (rst_n) begin
            if (resume) consume(EV_RES);
            if (prev_ack && !dma_ack_n) consume(EV_ACK);
            if (take_irq) begin
                consume(EV_IRQ);
                chk(irq_vector == 16'h1004, "R6", "vector", irq_vector, 16'h1004);
            end
            prev_ack = dma_ack_n;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bnd(input logic intr);
        @(negedge clk); insn_done = 1'b1; insn_intr = intr;
        @(negedge clk); insn_done = 1'b0; insn_intr = 1'b0;
    endtask

    task automatic pulse_set();
        @(negedge clk); ie_set = 1'b1;
        @(negedge clk); ie_set = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); ie_clr = 1'b1;
        @(negedge clk); ie_clr = 1'b0;
    endtask

    task automatic drained(input string req);
        tick(3);
        chk(kind_q.size() == 0, req, "missing events", kind_q.size(), 0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk(take_irq == 1'b0, "R1", "take_irq", take_irq, 0);
        chk(irq_vector == 16'h0, "R1", "vector", irq_vector, 0);
        chk(dma_ack_n == 1'b1, "R1", "ack", dma_ack_n, 1);
        chk(resume == 1'b0, "R1", "resume", resume, 0);

        // R2: flag clear at edge -> not latched, even if set later
        cur_req = "R2";
        irq_mask_n = 1'b0; tick(4);
        pulse_set();
        bnd(1'b1);
        drained("R2");
        irq_mask_n = 1'b1; tick(4);

        // R5: non-interruptible boundary ignored, then interruptible taken
        cur_req = "R5";
        irq_mask_n = 1'b0; tick(4);
        bnd(1'b0); tick(3);
        drained("R5");
        expect_ev(EV_IRQ, "R5");
        bnd(1'b1);
        drained("R5");
        irq_mask_n = 1'b1; tick(4);

        // R3: line returns high before boundary -> dropped
        cur_req = "R3";
        irq_mask_n = 1'b0; tick(4);
        irq_mask_n = 1'b1; tick(4);
        bnd(1'b1);
        drained("R3");

        // R2: flag cleared after latch -> not taken at boundary
        cur_req = "R2";
        irq_mask_n = 1'b0; tick(4);
        pulse_clr();
        bnd(1'b1);
        drained("R2");
        irq_mask_n = 1'b1; tick(4);

        // R4: non-maskable with flag clear
        cur_req = "R4";
        irq_force_n = 1'b0; tick(4);
        expect_ev(EV_IRQ, "R4");
        bnd(1'b1);
        drained("R4");
        irq_force_n = 1'b1; tick(4);

        // R6: both kinds pending, one per boundary
        cur_req = "R6";
        pulse_set();
        irq_mask_n = 1'b0; irq_force_n = 1'b0; tick(4);
        expect_ev(EV_IRQ, "R6");
        bnd(1'b1);
        drained("R6");
        expect_ev(EV_IRQ, "R6");
        bnd(1'b1);
        drained("R6");
        irq_mask_n = 1'b1; irq_force_n = 1'b1; tick(4);

        // R7 / R11 / R9: grant, hold, release (flag cleared)
        cur_req = "R7";
        pulse_clr();
        dma_req_n = 1'b0; tick(4);
        expect_ev(EV_ACK, "R7");
        bnd(1'b1);
        tick(10);
        chk(dma_ack_n == 1'b0, "R7", "ack held low", dma_ack_n, 0);
        cur_req = "R11";
        irq_force_n = 1'b0; tick(4);
        bnd(1'b1); bnd(1'b1);
        chk(dma_ack_n == 1'b0, "R11", "ack during hold", dma_ack_n, 0);
        drained("R11");
        cur_req = "R9";
        expect_ev(EV_RES, "R9");
        expect_ev(EV_IRQ, "R10");
        dma_req_n = 1'b1; tick(5);
        chk(dma_ack_n == 1'b1, "R9", "ack released", dma_ack_n, 1);
        drained("R9");
        irq_force_n = 1'b1; tick(4);

        // R8: request withdrawn before any boundary
        cur_req = "R8";
        dma_req_n = 1'b0; tick(10);
        dma_req_n = 1'b1; tick(4);
        bnd(1'b1);
        chk(dma_ack_n == 1'b1, "R8", "no ack", dma_ack_n, 1);
        drained("R8");

        // R10: maskable interrupt and DMA at the same boundary
        cur_req = "R10";
        pulse_set();
        irq_mask_n = 1'b0; dma_req_n = 1'b0; tick(4);
        expect_ev(EV_ACK, "R10");
        bnd(1'b1);
        tick(3);
        chk(take_irq == 1'b0, "R10", "no take while granted", take_irq, 0);
        expect_ev(EV_RES, "R10");
        expect_ev(EV_IRQ, "R10");
        dma_req_n = 1'b1; tick(5);
        drained("R10");
        irq_mask_n = 1'b1; tick(4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule